// File: doc/BRIEF.md
# Legacy A20 Gate Controller

This block reproduces the small part of an old keyboard-controller chip that owns the A20 address gate. Host software reaches it through byte-wide I/O writes and reads at two addresses. The command/status port sits at 0x64 and the data port at 0x60. To change the gate, software first writes the "write output port" command 0xD1 to 0x64. The next byte it writes to 0x60 is then latched into an 8-bit output port register. Bit 1 of that register is the A20 enable line.

The real controller was slow, and this model keeps that behaviour. Every accepted byte keeps the controller busy for `BUSY_CYCLES` clock cycles. While it is busy, the busy flag in the status byte is set, and software is expected to poll that flag before it writes again. A write that arrives while the controller is busy is dropped, and a sticky error flag records it. A latched data byte reaches the output port, and so the A20 line, only in the cycle after its busy period has ended.

Top module: `a20_gate_ctl`

## Requirements
- R1: After reset, the output port register reads 0x00, `a20_en` is 0 and the status byte is 0x00.
- R2: An accepted write of 0xD1 to address 0x64 arms the controller, which is shown as status bit 3 = 1.
- R3: When the controller is armed, the next accepted write to address 0x60 is latched into the output port register. That write also disarms the controller, and a read of 0x60 returns the latched byte.
- R4: `a20_en` equals bit 1 of the output port register. Arming and then writing 0xDF gives `a20_en` = 1, and arming and then writing 0xDD gives `a20_en` = 0.
- R5: Each accepted write to 0x60 or 0x64 holds the busy flag (status bit 1, mask 0x02) at 1 for exactly `BUSY_CYCLES` clock cycles after its accepting edge.
- R6: A write to 0x60 or 0x64 made while the controller is busy changes neither the output port nor the armed state. It sets the error flag (status bit 6), which stays set until reset.
- R7: An accepted write to 0x60 while the controller is not armed leaves the output port register unchanged.
- R8: An accepted write to 0x64 of any byte other than 0xD1 clears the armed state.
- R9: A latched data byte appears on the output port and on `a20_en` at the first clock edge after the edge on which busy falls, and never earlier.
- R10: Writes to any address other than 0x60 and 0x64 have no effect and do not make the controller busy. Reads of such addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | 8 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one byte per cycle |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data: status at 0x64, output port at 0x60, otherwise 0 |
| status | output | 8 | Status byte (bit 1 busy, bit 3 armed, bit 6 error) |
| a20_en | output | 1 | A20 gate enable |

## Verification
The main path is driven from a table of command/data pairs:
- Properly armed writes of 0xDF, 0xDD, 0x02, 0x00 and 0xFF. These separate a correct full-byte latch from a single-bit latch or an inverted gate.
- A pair that uses a non-0xD1 command. This shows whether the armed state is really cleared.

Directed sequences then cover the following:
- The busy window is timed cycle by cycle, with the output port checked against it, to find off-by-one errors in the delay and an output that changes too early.
- A data byte is written during the busy window, to show that it is dropped and that the error flag sticks.
- Stray addresses are written and read.
- Reset is applied again to clear the error flag.

// File: rtl/a20_gate_pkg.sv
package a20_gate_pkg;
  localparam logic [7:0] PORT_DATA      = 8'h60;
  localparam logic [7:0] PORT_CMD       = 8'h64;
  localparam logic [7:0] CMD_WR_OUTPORT = 8'hD1;
  localparam logic [7:0] OUTPORT_RESET  = 8'h00;
  localparam int         A20_BIT        = 1;
  localparam int         ST_BUSY        = 1;
  localparam int         ST_ARMED       = 3;
  localparam int         ST_ERR         = 6;

  function automatic logic [7:0] pack_status(input logic busy, input logic armed,
                                             input logic err);
    logic [7:0] s;
    s           = 8'h00;
    s[ST_BUSY]  = busy;
    s[ST_ARMED] = armed;
    s[ST_ERR]   = err;
    return s;
  endfunction

  function automatic logic is_port(input logic [7:0] addr);
    return (addr == PORT_DATA) || (addr == PORT_CMD);
  endfunction
endpackage

// File: rtl/a20_busy_timer.sv
module a20_busy_timer #(
  parameter int BUSY_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(BUSY_CYCLES);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R5
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start); // R6
endmodule

// File: rtl/a20_cmd_decoder.sv
module a20_cmd_decoder
  import a20_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_acc,
  input  logic       data_acc,
  input  logic [7:0] wdata,
  input  logic       commit,
  output logic       armed,
  output logic       pend_valid,
  output logic [7:0] pend_data
);
  logic take_data;
  assign take_data = data_acc && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed <= 1'b0;
    else if (cmd_acc)  armed <= (wdata == CMD_WR_OUTPORT);
    else if (data_acc) armed <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_data  <= '0;
    end else if (take_data) begin
      pend_valid <= 1'b1;
      pend_data  <= wdata;
    end else if (commit) begin
      pend_valid <= 1'b0;
    end
  end

  AST_UNARMED_DATA_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !armed) |=> !pend_valid); // R7
  AST_OTHER_CMD_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_acc && wdata != CMD_WR_OUTPORT) |=> !armed); // R8
  AST_DATA_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> !armed); // R3
endmodule

// File: rtl/a20_outport_reg.sv
module a20_outport_reg
  import a20_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       commit,
  input  logic [7:0] pend_data,
  output logic [7:0] outport
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      outport <= OUTPORT_RESET;
    else if (commit) outport <= pend_data;
  end

  AST_OUTPORT_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(outport) |-> $past(commit)); // R9
endmodule

// File: rtl/a20_gate_ctl.sv
module a20_gate_ctl
  import a20_gate_pkg::*;
#(
  parameter int BUSY_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] io_addr,
  input  logic       io_wr,
  input  logic [7:0] io_wdata,
  input  logic       io_rd,
  output logic [7:0] io_rdata,
  output logic [7:0] status,
  output logic       a20_en
);
  logic       wr_hit, accept, dropped, cmd_acc, data_acc;
  logic       busy, armed, pend_valid, commit, err;
  logic [7:0] pend_data, outport;

  assign wr_hit   = io_wr && is_port(io_addr);
  assign accept   = wr_hit && !busy;
  assign dropped  = wr_hit && busy;
  assign cmd_acc  = accept && (io_addr == PORT_CMD);
  assign data_acc = accept && (io_addr == PORT_DATA);
  assign commit   = pend_valid && !busy;

  a20_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .busy(busy)
  );

  a20_cmd_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_acc(cmd_acc), .data_acc(data_acc),
    .wdata(io_wdata), .commit(commit), .armed(armed),
    .pend_valid(pend_valid), .pend_data(pend_data)
  );

  a20_outport_reg u_oport (
    .clk(clk), .rst_n(rst_n), .commit(commit), .pend_data(pend_data),
    .outport(outport)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err <= 1'b0;
    else if (dropped) err <= 1'b1;
  end

  assign status = pack_status(busy, armed, err);
  assign a20_en = outport[A20_BIT];

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd) begin
      if (io_addr == PORT_CMD)       io_rdata = status;
      else if (io_addr == PORT_DATA) io_rdata = outport;
    end
  end

  AST_A20_OFF_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !a20_en); // R1
  AST_DROP_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    dropped |=> err); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R6
  AST_DROP_KEEPS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    dropped |=> $stable(armed)); // R6
  AST_A20_NOT_DURING_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(a20_en) |-> !$past(busy)); // R9
  AST_STRAY_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !is_port(io_addr) && !busy) |=> !busy); // R10
endmodule

// File: tb/test_a20_gate_ctl.sv
module test_a20_gate_ctl;
  localparam int N = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] io_addr = 8'h00;
  logic       io_wr = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic       io_rd = 1'b0;
  logic [7:0] io_rdata, status;
  logic       a20_en;
  int         n_checks = 0;
  int         n_fails  = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  a20_gate_ctl #(.BUSY_CYCLES(N)) i_a20_gate_ctl (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rd(io_rd), .io_rdata(io_rdata),
    .status(status), .a20_en(a20_en)
  );

  // {command, data, expected output port}
  localparam logic [23:0] VEC [6] = '{
    {8'hD1, 8'hDF, 8'hDF},
    {8'hD1, 8'hDD, 8'hDD},
    {8'hAA, 8'h55, 8'hDD},
    {8'hD1, 8'h02, 8'h02},
    {8'hD1, 8'h00, 8'h00},
    {8'hD1, 8'hFF, 8'hFF}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    rd(8'h64, s);
    while (s[1]) begin
      @(negedge clk);
      rd(8'h64, s);
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 20000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    rd(8'h60, rv); check("R1 outport", rv, 8'h00);
    check("R1 a20", {7'd0, a20_en}, 8'h00);
    check("R1 status", status, 8'h00);

    // table walk: R3 R4 R7 R8
    for (int i = 0; i < 6; i++) begin
      wr(8'h64, VEC[i][23:16]); wait_idle();
      wr(8'h60, VEC[i][15:8]);  wait_idle();
      rd(8'h60, rv);
      check("R3/R7/R8 outport", rv, VEC[i][7:0]);
      check("R4 a20", {7'd0, a20_en}, {7'd0, VEC[i][1]});
    end

    // R2 arm flag and R8 disarm
    wr(8'h64, 8'hD1); wait_idle();
    check("R2 armed", status & 8'h08, 8'h08);
    wr(8'h64, 8'h20); wait_idle();
    check("R8 disarmed", status & 8'h08, 8'h00);
    // R7 unarmed data write
    wr(8'h60, 8'h00); wait_idle();
    rd(8'h60, rv); check("R7 outport kept", rv, 8'hFF);
    // R3 disarm after data
    wr(8'h64, 8'hD1); wait_idle();
    wr(8'h60, 8'hDD); wait_idle();
    check("R3 disarmed", status & 8'h08, 8'h00);

    // R5 / R9 cycle timing: outport DD -> DF
    wr(8'h64, 8'hD1); wait_idle();
    wr(8'h60, 8'hDF);
    for (int j = 0; j <= N + 1; j++) begin
      if (j < N) check("R5 busy", status & 8'h02, 8'h02);
      else       check("R5 idle", status & 8'h02, 8'h00);
      rd(8'h60, rv);
      check("R9 outport timing", rv, (j <= N) ? 8'hDD : 8'hDF);
      @(negedge clk);
    end
    check("R4 a20 on", {7'd0, a20_en}, 8'h01);

    // R6 write while busy
    wr(8'h64, 8'hD1);
    wr(8'h60, 8'hDD);            // arrives while busy
    wait_idle();
    rd(8'h60, rv); check("R6 outport unchanged", rv, 8'hDF);
    check("R6 err and armed", status, 8'h48);
    wr(8'h60, 8'h00); wait_idle();
    rd(8'h60, rv); check("R6 armed kept", rv, 8'h00);
    check("R6 err sticky", status, 8'h40);

    // R10 stray address
    wr(8'h70, 8'hD1);
    check("R10 no busy", status & 8'h02, 8'h00);
    rd(8'h70, rv); check("R10 read zero", rv, 8'h00);
    wr(8'h60, 8'hDF); wait_idle();
    rd(8'h60, rv); check("R10 no arm", rv, 8'h00);

    // R1 reset again clears error
    do_reset();
    check("R1 status after reset", status, 8'h00);
    rd(8'h60, rv); check("R1 outport after reset", rv, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule